// File: doc/BRIEF.md
# Serial Channel Error and Status Flags

This block holds the status flags of one channel of a serial unit that runs either as a UART or as a clocked synchronous link. The receive and transmit datapaths send it single-cycle event pulses: end of a reception, the sampled stop-bit result, the parity comparison result, CPU writes and reads of the data register, a move of the data register into the shift register, and the start and end of a transfer. From these the block keeps three sticky error flags (overrun, parity, framing) and two live flags (transfer busy, data buffer full). It presents them as one 16-bit read-only word.

Software clears the error flags through a separate write-one-to-clear strobe and mask. Overrun has three causes. The first is a reception that lands on unread data while the receiver is enabled. The second is a CPU write to a data register that is already full, which discards the held data. The third is a slave-mode synchronous transfer with transmit enabled that starts while no transmit data is loaded.

Two small state machines carry the live flags. The transfer machine has the states XF_IDLE and XF_ACTIVE. It goes from XF_IDLE to XF_ACTIVE on `xfer_start` and from XF_ACTIVE back to XF_IDLE on `xfer_end`. The buffer machine has the states BUF_EMPTY and BUF_FULL. It goes to BUF_FULL on any load, which is a CPU write or a reception with the receiver enabled. It goes to BUF_EMPTY on a CPU read or a shift-register load when no load happens in the same cycle.

Top module: `sci_err_status`

## Requirements
- R1: After reset the status word is 0x0000. Bits 15..7, 4 and 3 always read 0.
- R2: Bit 6 (busy) becomes 1 the cycle after `xfer_start` while idle. It becomes 0 the cycle after `xfer_end` while active.
- R3: Bit 5 (buffer full) becomes 1 the cycle after `cpu_wr`, or after `rx_done` with `rx_en`=1. It becomes 0 the cycle after `cpu_rd` or `shift_load` when there is no load in that cycle. A load wins over a drain.
- R4: Bit 2 (framing) sets on `rx_done` with `uart_mode`=1 and `stop_ok`=0.
- R5: Bit 1 (parity) sets on `rx_done` with `uart_mode`=1 and `parity_ok`=0.
- R6: Bit 0 (overrun) sets when `rx_done` arrives with `rx_en`=1 while bit 5 is 1.
- R7: Bit 0 sets when `cpu_wr` arrives while bit 5 is 1. Bit 5 stays 1.
- R8: Bit 0 sets when `xfer_start` arrives with `uart_mode`=0, `slave_mode`=1, `tx_en`=1 and bit 5 is 0.
- R9: With `clr_wr`=1, mask bit 0, 1 or 2 clears overrun, parity or framing respectively. A mask bit of 0 leaves its flag unchanged.
- R10: When a set event and a clear of the same flag fall in one cycle, the flag is 1 afterwards.
- R11: With `uart_mode`=0, the parity and framing flags change only through a clear.
- R12: With parameter `HAS_FRAMING`=0, bit 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_mode | input | 1 | 1 = UART, 0 = synchronous |
| slave_mode | input | 1 | Synchronous slave (external clock) |
| tx_en | input | 1 | Transmit enabled |
| rx_en | input | 1 | Receive enabled |
| rx_done | input | 1 | Pulse: reception finished, data loaded |
| stop_ok | input | 1 | Stop bit valid, qualified by rx_done |
| parity_ok | input | 1 | Parity matched, qualified by rx_done |
| cpu_wr | input | 1 | Pulse: CPU write to data register |
| cpu_rd | input | 1 | Pulse: CPU read of data register |
| shift_load | input | 1 | Pulse: data register moved to shift register |
| xfer_start | input | 1 | Pulse: transfer starts |
| xfer_end | input | 1 | Pulse: transfer ends |
| clr_wr | input | 1 | Clear strobe |
| clr_mask | input | 3 | Clear mask: bit2 framing, bit1 parity, bit0 overrun |
| status | output | 16 | Status word |

## Verification
The bench targets same-cycle collisions. One is a clear landing with a set of the same flag, where a wrong priority would silently lose an error. Another is a load landing with a read, where a wrong order would drop the buffer-full flag and hide a later overrun. It drives slave transfer starts with the buffer empty and with it full, so that an overrun qualified on the wrong buffer state shows up. It also gives receptions with bad stop and parity bits in synchronous mode, where a flag that updates there would set falsely. A second instance without framing support shows whether bit 2 leaks through.

// File: rtl/sci_stat_pkg.sv
package sci_stat_pkg;
    localparam int STAT_W   = 16;
    localparam int POS_OVR  = 0;
    localparam int POS_PAR  = 1;
    localparam int POS_FRM  = 2;
    localparam int POS_FULL = 5;
    localparam int POS_BUSY = 6;
    localparam int N_ERR    = 3;

    typedef enum logic { BUF_EMPTY = 1'b0, BUF_FULL = 1'b1 } buf_state_e;
    typedef enum logic { XF_IDLE = 1'b0, XF_ACTIVE = 1'b1 } xf_state_e;
endpackage

// File: rtl/sci_buf_fsm.sv
module sci_buf_fsm
    import sci_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic drain,
    output logic full
);
    buf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (load) state_d = BUF_FULL;
            BUF_FULL:  if (drain && !load) state_d = BUF_EMPTY;
            default:   state_d = BUF_EMPTY;
        endcase
    end

    always_comb full = (state_q == BUF_FULL);

    // R3
    load_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full);
    // R3
    drain_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !load) |=> !full);
endmodule

// File: rtl/sci_xfer_fsm.sv
module sci_xfer_fsm
    import sci_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic busy
);
    xf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE:   if (start) state_d = XF_ACTIVE;
            XF_ACTIVE: if (stop)  state_d = XF_IDLE;
            default:   state_d = XF_IDLE;
        endcase
    end

    always_comb busy = (state_q == XF_ACTIVE);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    // R2
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop) |=> !busy);
endmodule

// File: rtl/sci_err_flag.sv
module sci_err_flag #(
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    always_comb flag = PRESENT ? flag_q : 1'b0;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_q);
    // R9
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag_q);
endmodule

// File: rtl/sci_err_status.sv
module sci_err_status
    import sci_stat_pkg::*;
#(
    parameter bit HAS_FRAMING = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        uart_mode,
    input  logic        slave_mode,
    input  logic        tx_en,
    input  logic        rx_en,
    input  logic        rx_done,
    input  logic        stop_ok,
    input  logic        parity_ok,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic        shift_load,
    input  logic        xfer_start,
    input  logic        xfer_end,
    input  logic        clr_wr,
    input  logic [2:0]  clr_mask,
    output logic [15:0] status
);
    logic             full, busy;
    logic             rx_load, buf_load, buf_drain;
    logic [N_ERR-1:0] err_set, err_clr, err_flag;

    always_comb begin
        rx_load   = rx_done && rx_en;
        buf_load  = cpu_wr || rx_load;
        buf_drain = cpu_rd || shift_load;
    end

    sci_buf_fsm u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (buf_load),
        .drain (buf_drain),
        .full  (full)
    );

    sci_xfer_fsm u_xfer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (xfer_start),
        .stop  (xfer_end),
        .busy  (busy)
    );

    always_comb begin
        err_set[POS_OVR] = (rx_load && full) || (cpu_wr && full) ||
                           (xfer_start && !uart_mode && slave_mode && tx_en && !full);
        err_set[POS_PAR] = rx_done && uart_mode && !parity_ok;
        err_set[POS_FRM] = rx_done && uart_mode && !stop_ok;
        err_clr          = clr_mask & {N_ERR{clr_wr}};
    end

    for (genvar i = 0; i < N_ERR; i++) begin : g_err
        localparam bit KEEP = (i == POS_FRM) ? HAS_FRAMING : 1'b1;
        sci_err_flag #(.PRESENT(KEEP)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (err_set[i]),
            .clr   (err_clr[i]),
            .flag  (err_flag[i])
        );
    end

    always_comb begin
        status           = '0;
        status[POS_BUSY] = busy;
        status[POS_FULL] = full;
        status[POS_FRM]  = err_flag[POS_FRM];
        status[POS_PAR]  = err_flag[POS_PAR];
        status[POS_OVR]  = err_flag[POS_OVR];
    end

    // R1
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[15:7] == 9'd0) && (status[4:3] == 2'd0));
    // R6
    rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_en && status[POS_FULL]) |=> status[POS_OVR]);
    // R7
    wr_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && status[POS_FULL]) |=> (status[POS_OVR] && status[POS_FULL]));
    // R8
    slave_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !uart_mode && slave_mode && tx_en && !status[POS_FULL])
        |=> status[POS_OVR]);
    // R11
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uart_mode && !(clr_wr && clr_mask[POS_PAR])) |=> $stable(status[POS_PAR]));
endmodule

// File: tb/sci_err_status_bench.sv
module sci_err_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uart_mode = 1'b0, slave_mode = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic rx_done = 1'b0, stop_ok = 1'b1, parity_ok = 1'b1;
    logic cpu_wr = 1'b0, cpu_rd = 1'b0, shift_load = 1'b0;
    logic xfer_start = 1'b0, xfer_end = 1'b0, clr_wr = 1'b0;
    logic [2:0] clr_mask = 3'b000;
    logic [15:0] status, status_nf;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int m_busy = 0, m_full = 0, m_fe = 0, m_pe = 0, m_ov = 0;

    always #2 clk = ~clk;

    sci_err_status u_sci_err_status (
        .clk(clk), .rst_n(rst_n), .uart_mode(uart_mode), .slave_mode(slave_mode),
        .tx_en(tx_en), .rx_en(rx_en), .rx_done(rx_done), .stop_ok(stop_ok),
        .parity_ok(parity_ok), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .shift_load(shift_load), .xfer_start(xfer_start), .xfer_end(xfer_end),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .status(status));

    sci_err_status #(.HAS_FRAMING(1'b0)) u_nofe (
        .clk(clk), .rst_n(rst_n), .uart_mode(uart_mode), .slave_mode(slave_mode),
        .tx_en(tx_en), .rx_en(rx_en), .rx_done(rx_done), .stop_ok(stop_ok),
        .parity_ok(parity_ok), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .shift_load(shift_load), .xfer_start(xfer_start), .xfer_end(xfer_end),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .status(status_nf));

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (rst_n) begin
            bit load, ovs, fes, pes;
            load = cpu_wr || (rx_done && rx_en);
            ovs = 0;
            if (m_full != 0 && (cpu_wr || (rx_done && rx_en))) ovs = 1;
            if (!uart_mode && slave_mode && tx_en && xfer_start && m_full == 0) ovs = 1;
            fes = uart_mode && rx_done && !stop_ok;
            pes = uart_mode && rx_done && !parity_ok;
            if (ovs) m_ov = 1; else if (clr_wr && clr_mask[0]) m_ov = 0;
            if (pes) m_pe = 1; else if (clr_wr && clr_mask[1]) m_pe = 0;
            if (fes) m_fe = 1; else if (clr_wr && clr_mask[2]) m_fe = 0;
            if (load) m_full = 1; else if (cpu_rd || shift_load) m_full = 0;
            if (m_busy == 0 && xfer_start) m_busy = 1;
            else if (m_busy != 0 && xfer_end) m_busy = 0;
        end
    end

    // Compare against the reference away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(status[6], m_busy != 0, "R2 busy vs model");
            chk(status[5], m_full != 0, "R3 full vs model");
            chk(status[2], m_fe != 0,   "R4 framing vs model");
            chk(status[1], m_pe != 0,   "R5 parity vs model");
            chk(status[0], m_ov != 0,   "R6 overrun vs model");
            chk((status[15:7] == 0) && (status[4:3] == 0), 1'b1, "R1 spare bits zero");
            chk(status_nf[2], 1'b0, "R12 framing absent");
            chk(status_nf[1:0] == status[1:0], 1'b1, "R12 other flags match");
        end
        if (cyc > 200000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic quiet();
        rx_done = 0; stop_ok = 1; parity_ok = 1; cpu_wr = 0; cpu_rd = 0;
        shift_load = 0; xfer_start = 0; xfer_end = 0; clr_wr = 0; clr_mask = 3'b000;
    endtask

    task automatic tick();
        @(negedge clk);
        #0.5 quiet();
    endtask

    initial begin
        quiet();
        repeat (3) @(negedge clk);
        chk(status == 16'h0000, 1'b1, "R1 reset value");
        rst_n = 1;
        @(negedge clk); #0.5;
        uart_mode = 1; rx_en = 1;
        cpu_wr = 1; tick();
        chk(status[5], 1'b1, "R3 full after write");
        cpu_wr = 1; tick();
        chk(status[0], 1'b1, "R7 overrun on write to full");
        chk(status[5], 1'b1, "R7 full held");
        clr_wr = 1; clr_mask = 3'b001; tick();
        chk(status[0], 1'b0, "R9 overrun cleared");
        cpu_rd = 1; tick();
        chk(status[5], 1'b0, "R3 read empties");
        rx_done = 1; stop_ok = 0; tick();
        chk(status[2], 1'b1, "R4 framing set");
        chk(status[1], 1'b0, "R5 parity clean");
        chk(status_nf[2], 1'b0, "R12 no framing bit");
        rx_done = 1; parity_ok = 0; tick();
        chk(status[1], 1'b1, "R5 parity set");
        chk(status[0], 1'b1, "R6 overrun on receive to full");
        clr_wr = 1; clr_mask = 3'b000; tick();
        chk(status[2], 1'b1, "R9 zero mask keeps flag");
        clr_wr = 1; clr_mask = 3'b111; rx_done = 1; stop_ok = 0; tick();
        chk(status[2], 1'b1, "R10 set beats clear framing");
        chk(status[1], 1'b0, "R9 parity cleared");
        chk(status[0], 1'b1, "R10 set beats clear overrun");
        clr_wr = 1; clr_mask = 3'b011; cpu_rd = 1; uart_mode = 0; slave_mode = 1; tx_en = 1; tick();
        rx_done = 1; parity_ok = 0; stop_ok = 1; tick();
        chk(status[1], 1'b0, "R11 parity held in sync mode");
        chk(status[2], 1'b1, "R11 framing held in sync mode");
        cpu_rd = 1; tick();
        xfer_start = 1; tick();
        chk(status[0], 1'b1, "R8 slave start with no data");
        chk(status[6], 1'b1, "R2 busy set");
        xfer_end = 1; tick();
        chk(status[6], 1'b0, "R2 busy cleared");
        cpu_wr = 1; tick();
        cpu_rd = 1; cpu_wr = 1; tick();
        chk(status[5], 1'b1, "R3 load wins over read");

        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 16) == 0) uart_mode = $urandom;
            if (($urandom % 16) == 0) slave_mode = $urandom;
            if (($urandom % 16) == 0) tx_en = $urandom;
            if (($urandom % 16) == 0) rx_en = $urandom;
            rx_done    = ($urandom % 5) == 0;
            stop_ok    = ($urandom % 3) != 0;
            parity_ok  = ($urandom % 3) != 0;
            cpu_wr     = ($urandom % 6) == 0;
            cpu_rd     = ($urandom % 5) == 0;
            shift_load = ($urandom % 8) == 0;
            xfer_start = ($urandom % 6) == 0;
            xfer_end   = ($urandom % 6) == 0;
            clr_wr     = ($urandom % 4) == 0;
            clr_mask   = 3'($urandom);
            tick();
        end
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule